// File: doc/BRIEF.md
# Four-Segment Piecewise Gain Mapper

This block reshapes a stream of 10-bit linear pixel codes through a programmable four-piece linear transfer curve. The output code range is split into four equal quarters, and each quarter has its own slope taken from a 4-bit gain field. With equal fields it acts as a plain global gain. With falling fields (steep at the dark end, flat at the bright end) it gives a rough gamma curve.

The slope is chosen by the quarter of the *output* range being produced. The block therefore works out where each quarter starts in the input domain. It uses the width of every earlier segment for this, and it recomputes these input breakpoints from the gain fields. New gain and resolution settings are sampled only on a frame boundary strobe, so one frame never mixes two curves. The mapped code leaves a fixed two-stage pipeline with a matching valid strobe. When a reduced output resolution is selected, its low bits are cleared.

Top module: `pgm_gain_mapper`

## Requirements
- R1: After reset the active curve has segment gain fields 7, 7, 15, 15 (segment 1 to segment 4) and 10-bit resolution. It stays in force until the first frame strobe. While reset is held and right after it, `pix_valid_o` and `pix_code_o` are 0.
- R2: Segment k (k = 0..3) produces output codes from k*256 upward, with slope (g_k + 1)/8. Here g_k is bits [4k+3:4k] of `seg_gain_i`.
- R3: The input breakpoints are bp_0 = 0 and bp_(k+1) = bp_k + ceil(2048 / (g_k + 1)). An input x belongs to the highest segment k with x >= bp_k.
- R4: The output is k*256 + floor((x - bp_k) * (g_k + 1) / 8), saturated at 1023.
- R5: When all four gain fields are 7, the output equals the input for every code.
- R6: The resolution code `res_sel_i` works as follows. 00 selects 8-bit output, with bits [1:0] forced to 0. 01 selects 9-bit output, with bit [0] forced to 0. 10 and 11 select full 10-bit output.
- R7: A sample accepted with `pix_valid_i` high appears with `pix_valid_o` high exactly two clock edges later. No other cycle raises `pix_valid_o`.
- R8: `seg_gain_i` and `res_sel_i` are sampled only at an edge where `frame_sync_i` is high. A sample accepted at that same edge still uses the previous curve. Samples accepted later use the new one.
- R9: While `pix_valid_o` is low, `pix_code_o` holds the last mapped code.
- R10: A sample that falls in segment 0 never produces an output above 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | Frame boundary strobe that loads new settings |
| seg_gain_i | input | 16 | Four 4-bit segment gain fields, segment 1 in bits [3:0] |
| res_sel_i | input | 2 | Output resolution code |
| pix_valid_i | input | 1 | Input sample strobe |
| pix_code_i | input | 10 | Linear input code |
| pix_valid_o | output | 1 | Output sample strobe |
| pix_code_o | output | 10 | Mapped output code |

## Verification
The hardest case to reach from the ports is a gain change that arrives together with a sample on the frame boundary edge. That sample must still follow the old curve, and the curve must not move while the strobe stays low. The bench sets up this case on purpose. It first presents new gain values without the strobe and sweeps inputs against the old curve. It then raises the strobe and the valid strobe at the same edge with a code whose mapping differs between the two curves, and finally sweeps again under the new curve. The breakpoint rounding is exercised by full 1024-code sweeps with extreme fields (all 0, all 15, falling), which put breakpoints at uneven and out-of-range positions.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    // Width in input codes of one segment: the smallest input step whose
    // scaled value covers a whole output quarter, ceil(seg_codes*2^frac / (g+1)).
    function automatic int unsigned seg_span(input int unsigned seg_codes,
                                             input int unsigned frac_sh,
                                             input int unsigned gain_code);
        int unsigned num;
        int unsigned den;
        num = seg_codes << frac_sh;
        den = gain_code + 1;
        return (num + den - 1) / den;
    endfunction

    // Resolution codes
    localparam logic [1:0] RES_8B  = 2'b00;
    localparam logic [1:0] RES_9B  = 2'b01;
    localparam logic [1:0] RES_10B = 2'b10;

endpackage

// File: rtl/pgm_curve_regs.sv
module pgm_curve_regs #(
    parameter int CODE_W  = 10,
    parameter int GAIN_W  = 4,
    parameter int NSEG    = 4,
    parameter int FRAC_SH = 3,
    parameter logic [NSEG*GAIN_W-1:0] RST_GAINS = 16'hFF77,
    localparam int SEG_OUT = (1 << CODE_W) / NSEG,
    localparam int BP_W    = CODE_W + FRAC_SH + 1,
    localparam int NGAIN   = 1 << GAIN_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [NSEG*GAIN_W-1:0]            gain_in,
    input  logic [1:0]                        res_in,
    output logic [NSEG-1:0][GAIN_W-1:0]       gain_q,
    output logic [NSEG-1:0][BP_W-1:0]         bp_q,
    output logic [1:0]                        res_q
);

    typedef struct packed {
        logic [NSEG-1:0][GAIN_W-1:0] gain;
        logic [NSEG-1:0][BP_W-1:0]   bp;
        logic [1:0]                  res;
    } curve_t;

    // Segment width for each possible gain code, built at elaboration
    logic [BP_W-1:0] span_tab [NGAIN];
    for (genvar g = 0; g < NGAIN; g++) begin : g_span
        assign span_tab[g] = BP_W'(pgm_pkg::seg_span(SEG_OUT, FRAC_SH, g));
    end

    curve_t cur_d, cur_q;
    curve_t new_curve, rst_curve;

    // Breakpoints from the incoming fields
    always_comb begin
        for (int k = 0; k < NSEG; k++) begin
            new_curve.gain[k] = gain_in[k*GAIN_W +: GAIN_W];
        end
        new_curve.bp[0] = '0;
        for (int k = 1; k < NSEG; k++) begin
            new_curve.bp[k] = new_curve.bp[k-1] + span_tab[new_curve.gain[k-1]];
        end
        new_curve.res = res_in;
    end

    // Breakpoints of the reset curve
    always_comb begin
        for (int k = 0; k < NSEG; k++) begin
            rst_curve.gain[k] = RST_GAINS[k*GAIN_W +: GAIN_W];
        end
        rst_curve.bp[0] = '0;
        for (int k = 1; k < NSEG; k++) begin
            rst_curve.bp[k] = rst_curve.bp[k-1] + span_tab[rst_curve.gain[k-1]];
        end
        rst_curve.res = pgm_pkg::RES_10B;
    end

    always_comb begin
        cur_d = cur_q;
        if (load) begin
            cur_d = new_curve;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= rst_curve;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign gain_q = cur_q.gain;
    assign bp_q   = cur_q.bp;
    assign res_q  = cur_q.res;

endmodule

// File: rtl/pgm_seg_select.sv
module pgm_seg_select #(
    parameter int CODE_W  = 10,
    parameter int GAIN_W  = 4,
    parameter int NSEG    = 4,
    parameter int FRAC_SH = 3,
    localparam int BP_W   = CODE_W + FRAC_SH + 1,
    localparam int SEG_W  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [CODE_W-1:0]           in_code,
    input  logic [NSEG-1:0][GAIN_W-1:0] gain,
    input  logic [NSEG-1:0][BP_W-1:0]   bp,
    input  logic [1:0]                  res,
    output logic                        s1_valid,
    output logic [SEG_W-1:0]            s1_seg,
    output logic [CODE_W-1:0]           s1_off,
    output logic [GAIN_W-1:0]           s1_gain,
    output logic [1:0]                  s1_res
);

    typedef struct packed {
        logic              valid;
        logic [SEG_W-1:0]  seg;
        logic [CODE_W-1:0] off;
        logic [GAIN_W-1:0] gain;
        logic [1:0]        res;
    } stage_t;

    stage_t st_d, st_q;
    logic [SEG_W-1:0] seg_sel;
    logic [BP_W-1:0]  code_ext;

    assign code_ext = {{(BP_W-CODE_W){1'b0}}, in_code};

    // Highest segment whose breakpoint the input has reached
    always_comb begin
        seg_sel = '0;
        for (int k = 1; k < NSEG; k++) begin
            if (code_ext >= bp[k]) begin
                seg_sel = SEG_W'(k);
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.seg  = seg_sel;
            st_d.off  = in_code - bp[seg_sel][CODE_W-1:0];
            st_d.gain = gain[seg_sel];
            st_d.res  = res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid = st_q.valid;
    assign s1_seg   = st_q.seg;
    assign s1_off   = st_q.off;
    assign s1_gain  = st_q.gain;
    assign s1_res   = st_q.res;

endmodule

// File: rtl/pgm_seg_scale.sv
module pgm_seg_scale #(
    parameter int CODE_W  = 10,
    parameter int GAIN_W  = 4,
    parameter int NSEG    = 4,
    parameter int FRAC_SH = 3,
    localparam int SEG_OUT  = (1 << CODE_W) / NSEG,
    localparam int SEG_W    = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int PROD_W   = CODE_W + GAIN_W + 1,
    localparam int SUM_W    = PROD_W + 1,
    localparam int MAX_CODE = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [SEG_W-1:0]  s1_seg,
    input  logic [CODE_W-1:0] s1_off,
    input  logic [GAIN_W-1:0] s1_gain,
    input  logic [1:0]        s1_res,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } out_t;

    out_t o_d, o_q;
    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  sum;
    logic [CODE_W-1:0] sat_code;
    logic [CODE_W-1:0] low_mask;

    always_comb begin
        prod = PROD_W'(s1_off) * (PROD_W'(s1_gain) + PROD_W'(1));
        sum  = SUM_W'(s1_seg) * SUM_W'(SEG_OUT) + SUM_W'(prod >> FRAC_SH);
        if (sum > SUM_W'(MAX_CODE)) begin
            sat_code = CODE_W'(MAX_CODE);
        end else begin
            sat_code = sum[CODE_W-1:0];
        end
        case (s1_res)
            pgm_pkg::RES_8B: low_mask = ~CODE_W'(3);
            pgm_pkg::RES_9B: low_mask = ~CODE_W'(1);
            default:         low_mask = '1;
        endcase
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = s1_valid;
        if (s1_valid) begin
            o_d.code = sat_code & low_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_code  = o_q.code;

endmodule

// File: rtl/pgm_gain_mapper.sv
module pgm_gain_mapper #(
    parameter int CODE_W  = 10,
    parameter int GAIN_W  = 4,
    parameter int NSEG    = 4,
    parameter int FRAC_SH = 3,
    parameter logic [NSEG*GAIN_W-1:0] RST_GAINS = 16'hFF77,
    localparam int BP_W  = CODE_W + FRAC_SH + 1,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_sync_i,
    input  logic [NSEG*GAIN_W-1:0] seg_gain_i,
    input  logic [1:0]             res_sel_i,
    input  logic                   pix_valid_i,
    input  logic [CODE_W-1:0]      pix_code_i,
    output logic                   pix_valid_o,
    output logic [CODE_W-1:0]      pix_code_o
);

    logic [NSEG-1:0][GAIN_W-1:0] gain_q;
    logic [NSEG-1:0][BP_W-1:0]   bp_q;
    logic [1:0]                  res_q;

    logic              s1_valid;
    logic [SEG_W-1:0]  s1_seg;
    logic [CODE_W-1:0] s1_off;
    logic [GAIN_W-1:0] s1_gain;
    logic [1:0]        s1_res;

    pgm_curve_regs #(
        .CODE_W(CODE_W), .GAIN_W(GAIN_W), .NSEG(NSEG),
        .FRAC_SH(FRAC_SH), .RST_GAINS(RST_GAINS)
    ) curve_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_sync_i),
        .gain_in(seg_gain_i),
        .res_in (res_sel_i),
        .gain_q (gain_q),
        .bp_q   (bp_q),
        .res_q  (res_q)
    );

    pgm_seg_select #(
        .CODE_W(CODE_W), .GAIN_W(GAIN_W), .NSEG(NSEG), .FRAC_SH(FRAC_SH)
    ) select_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(pix_valid_i),
        .in_code (pix_code_i),
        .gain    (gain_q),
        .bp      (bp_q),
        .res     (res_q),
        .s1_valid(s1_valid),
        .s1_seg  (s1_seg),
        .s1_off  (s1_off),
        .s1_gain (s1_gain),
        .s1_res  (s1_res)
    );

    pgm_seg_scale #(
        .CODE_W(CODE_W), .GAIN_W(GAIN_W), .NSEG(NSEG), .FRAC_SH(FRAC_SH)
    ) scale_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_seg   (s1_seg),
        .s1_off   (s1_off),
        .s1_gain  (s1_gain),
        .s1_res   (s1_res),
        .out_valid(pix_valid_o),
        .out_code (pix_code_o)
    );

endmodule

// File: rtl/pgm_gain_mapper_chk.sv
module pgm_gain_mapper_chk #(
    parameter int CODE_W  = 10,
    parameter int NSEG    = 4,
    parameter int FRAC_SH = 3,
    localparam int BP_W    = CODE_W + FRAC_SH + 1,
    localparam int SEG_W   = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int SEG_OUT = (1 << CODE_W) / NSEG
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_sync_i,
    input logic                 pix_valid_i,
    input logic                 pix_valid_o,
    input logic [CODE_W-1:0]    pix_code_o,
    input logic [NSEG*BP_W-1:0] bp_vec,
    input logic                 s1_valid,
    input logic [SEG_W-1:0]     s1_seg
);

    logic [1:0] vpipe;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[0], pix_valid_i};
        end
    end

    // R7
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o == vpipe[1]);

    // R8
    curve_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync_i |=> $stable(bp_vec));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_o |-> $stable(pix_code_o));

    // R10
    first_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_seg == '0) |=> pix_code_o < CODE_W'(SEG_OUT));

endmodule

bind pgm_gain_mapper pgm_gain_mapper_chk #(
    .CODE_W(CODE_W), .NSEG(NSEG), .FRAC_SH(FRAC_SH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sync_i(frame_sync_i),
    .pix_valid_i (pix_valid_i),
    .pix_valid_o (pix_valid_o),
    .pix_code_o  (pix_code_o),
    .bp_vec      (bp_q),
    .s1_valid    (s1_valid),
    .s1_seg      (s1_seg)
);

// File: tb/pgm_gain_mapper_tb_top.sv
module pgm_gain_mapper_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync_i = 1'b0;
    logic [15:0] seg_gain_i = 16'h0;
    logic [1:0]  res_sel_i = 2'b10;
    logic        pix_valid_i = 1'b0;
    logic [9:0]  pix_code_i = '0;
    logic        pix_valid_o;
    logic [9:0]  pix_code_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    cur_g [4];
    int    cur_res;
    int    exp_q [$];
    int    in_q  [$];
    string tag_q [$];
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pgm_gain_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .frame_sync_i(frame_sync_i),
        .seg_gain_i(seg_gain_i), .res_sel_i(res_sel_i),
        .pix_valid_i(pix_valid_i), .pix_code_i(pix_code_i),
        .pix_valid_o(pix_valid_o), .pix_code_o(pix_code_o)
    );

    // Expected mapping from R2, R3, R4, R6
    function automatic int model(input int x, input int g[4], input int res);
        int bp[4];
        int seg;
        int v;
        int drop;
        bp[0] = 0;
        for (int k = 1; k < 4; k++) bp[k] = bp[k-1] + (2048 + g[k-1]) / (g[k-1] + 1);
        seg = 0;
        for (int k = 1; k < 4; k++) if (x >= bp[k]) seg = k;
        v = seg * 256 + ((x - bp[seg]) * (g[seg] + 1)) / 8;
        if (v > 1023) v = 1023;
        drop = (res == 0) ? 2 : (res == 1) ? 1 : 0;
        return (v >> drop) << drop;
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Output monitor, samples away from the active edge
    always @(negedge clk) begin
        if (rst_n && pix_valid_o) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R7 actual=unexpected valid expected=no output");
            end else begin
                int e;
                int x;
                string t;
                e = exp_q.pop_front();
                x = in_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (int'(pix_code_o) != e) begin
                    failures++;
                    $display("FAIL %s in=%0d actual=%0d expected=%0d", t, x, pix_code_o, e);
                end
            end
        end
    end

    task automatic send(input int x);
        @(posedge clk); #1;
        pix_valid_i = 1'b1;
        pix_code_i  = 10'(x);
        exp_q.push_back(model(x, cur_g, cur_res));
        in_q.push_back(x);
        tag_q.push_back(cur_tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            pix_valid_i = 1'b0;
        end
    endtask

    task automatic set_inputs(input int g0, input int g1, input int g2, input int g3, input int res);
        seg_gain_i = {4'(g3), 4'(g2), 4'(g1), 4'(g0)};
        res_sel_i  = 2'(res);
    endtask

    task automatic commit(input int g0, input int g1, input int g2, input int g3, input int res);
        set_inputs(g0, g1, g2, g3, res);
        @(posedge clk); #1;
        pix_valid_i  = 1'b0;
        frame_sync_i = 1'b1;
        @(posedge clk); #1;
        frame_sync_i = 1'b0;
        cur_g[0] = g0; cur_g[1] = g1; cur_g[2] = g2; cur_g[3] = g3;
        cur_res = res;
    endtask

    task automatic sweep(input string tag);
        cur_tag = tag;
        for (int x = 0; x < 1024; x++) send(x);
        idle(4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cur_g[0] = 7; cur_g[1] = 7; cur_g[2] = 15; cur_g[3] = 15;
        cur_res = 2;
        // Inputs hold other values; R1 demands the reset curve until a strobe
        set_inputs(0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", int'(pix_valid_o), 0);
        check("R1 code in reset", int'(pix_code_o), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 valid after reset", int'(pix_valid_o), 0);

        // R1: default curve 7,7,15,15 at 10 bits
        sweep("R1");

        // R5: identity
        commit(7, 7, 7, 7, 2);
        sweep("R5");

        // R2/R3/R4: falling gamma-like fields
        commit(15, 7, 3, 0, 2);
        sweep("R3");

        // R4 saturation and R3 short segments
        commit(15, 15, 15, 15, 2);
        sweep("R4");

        // R10: segment 0 spans the whole input range
        commit(0, 0, 0, 0, 3);
        sweep("R10");

        // R2: rising fields
        commit(1, 4, 9, 12, 2);
        sweep("R2");

        // R6: 8-bit and 9-bit resolution
        commit(15, 7, 3, 0, 0);
        sweep("R6");
        commit(12, 9, 5, 2, 1);
        sweep("R6");

        // R8: new fields without a strobe are ignored
        set_inputs(15, 15, 15, 15, 0);
        cur_tag = "R8";
        for (int x = 250; x < 520; x++) send(x);
        idle(3);
        // Strobe and sample at the same edge: old curve for that sample
        @(posedge clk); #1;
        frame_sync_i = 1'b1;
        pix_valid_i  = 1'b1;
        pix_code_i   = 10'd300;
        exp_q.push_back(model(300, cur_g, cur_res));
        in_q.push_back(300);
        tag_q.push_back("R8");
        @(posedge clk); #1;
        frame_sync_i = 1'b0;
        pix_valid_i  = 1'b0;
        cur_g[0] = 15; cur_g[1] = 15; cur_g[2] = 15; cur_g[3] = 15;
        cur_res = 0;
        for (int x = 250; x < 520; x++) send(x);
        idle(4);

        // R7: exact two-edge latency
        commit(7, 7, 7, 7, 2);
        idle(3);
        @(posedge clk); #1;
        pix_valid_i = 1'b1;
        pix_code_i  = 10'd300;
        exp_q.push_back(300);
        in_q.push_back(300);
        tag_q.push_back("R7");
        @(posedge clk); #1;
        pix_valid_i = 1'b0;
        check("R7 valid after one edge", int'(pix_valid_o), 0);
        @(posedge clk); #1;
        check("R7 valid after two edges", int'(pix_valid_o), 1);
        check("R7 code after two edges", int'(pix_code_o), 300);

        // R9: code held while no valid output
        idle(6);
        check("R9 valid idle", int'(pix_valid_o), 0);
        check("R9 held code", int'(pix_code_o), 300);
        check("R7 queue drained", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule